// File: doc/BRIEF.md
# Programmable Frame Sync Delay Generator

This block takes frame sync pulses that are sampled on a data clock and produces delayed copies of them. There are four independent channels, and each one has its own 16-bit control register. Software sets, per channel, how many data-clock periods the output waits after an input sync edge and how wide the output pulse is. The data clock is not used as a clock: it arrives as `dclk_en`, a one-cycle enable in the system clock domain. Every channel updates only on cycles where `dclk_en` is high.

A channel looks for a rising edge of its input sync, comparing the current sample with the one taken at the previous enabled cycle. On such an edge it loads the programmed delay and width. It counts the delay in enabled cycles and then drives a pulse that lasts 1, 2, 8 or 16 enabled periods. A delay of zero turns the channel into a plain combinational wire from input to output. In that case the width setting has no effect. When software runs a link that spends two data clocks per bit, it programs twice the delay; the block does not scale the value itself.

Top module: `fsync_delay_gen`

## Requirements
- R1: Channel `c` has a control register selected by `reg_addr == c`. The delay field sits in bits [9:0] and the width code in bits [15:14]. A write happens on a clock edge when `reg_we` is high. `reg_rdata` shows the register selected by `reg_addr` without a clock delay.
- R2: Bits [13:10] of every register always read as zero, whatever value was written to them.
- R3: Let the delay be N, with N ≥ 1. An input rising edge is sampled at some enabled cycle. The output goes high right after the N-th enabled edge that follows that sampling edge.
- R4: The width code gives the pulse length in enabled periods: 00 → 1, 01 → 2, 10 → 8, 11 → 16. The output falls right after the enabled edge W periods after it rose, where W is that length.
- R5: A pulse starts only on a rising edge, meaning input high now and low at the previous enabled sample. An input that stays high starts only one pulse.
- R6: Bypass applies when a channel is idle and its delay field is zero. Then `fs_out` equals `fs_in` combinationally, and the width code is ignored.
- R7: A new input rising edge during a delay or a pulse restarts that channel. The output drops and the channel counts again from the new edge, using the current register value. If that value has a zero delay, the channel goes idle in bypass.
- R8: Register writes made during a delay or a pulse do not change that delay or pulse. They take effect from the next input rising edge.
- R9: Two things clear all registers, edge history and channel activity. One is `rst_n` low, which acts at once. The other is `soft_rst` high, which acts at a clock edge and takes priority over writes and sync edges.
- R10: In cycles with `dclk_en` low, no channel's delay or pulse makes any progress.
- R11: The channels run independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| dclk_en | input | 1 | Data-clock enable; high for one clock per data-clock edge |
| fs_in | input | 4 | Input frame syncs, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register/channel select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| fs_out | output | 4 | Delayed frame syncs, one per channel |

## Verification
The bench holds a behavioural model of the channels and compares it against every output on every clock. The run covers the following cases:

- **Delays of 1 and 1023.** A counter that is off by one shifts every pulse by one period.
- **All four width codes.** A wrong width table gives a pulse that is too short or too long.
- **Restarts during a delay and during a pulse.** A design that ignores these edges emits stale pulses.
- **Register writes during a pulse.** A design that reads the register live bends a pulse already in progress.
- **Bypass entered with width code 11.** Here the width must be ignored.
- **Input held high, a sparse `dclk_en` and a software reset during a pulse.** These catch level-triggered starts, counting on the wrong clock and state that survives a reset.

// File: rtl/fsync_delay_gen.sv
module fsync_delay_gen #(
  parameter int NCH   = 4,
  parameter int DLY_W = 10,
  parameter int DW    = 16,
  parameter int AW    = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           dclk_en,
  input  logic [NCH-1:0] fs_in,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [NCH-1:0] fs_out
);
  localparam int RSV = DW - 2 - DLY_W;
  localparam int WCW = 5;
  localparam logic [1:0] IDLE = 2'd0, DELAY = 2'd1, PULSE = 2'd2;

  logic [DLY_W-1:0] cfg_sd [NCH];
  logic [1:0]       cfg_w  [NCH];
  logic [1:0]       ph     [NCH];
  logic [DLY_W-1:0] cnt    [NCH];
  logic [WCW-1:0]   wcnt   [NCH];
  logic [1:0]       wsel   [NCH];
  logic [NCH-1:0]   fs_prev;
  logic [NCH-1:0]   rise;
  logic             unused_rsv;

  function automatic logic [WCW-1:0] width_of(input logic [1:0] code);
    case (code)
      2'b00:   width_of = WCW'(1);
      2'b01:   width_of = WCW'(2);
      2'b10:   width_of = WCW'(8);
      default: width_of = WCW'(16);
    endcase
  endfunction

  assign unused_rsv = ^reg_wdata[DW-3:DLY_W];
  assign rise       = {NCH{dclk_en}} & fs_in & ~fs_prev;
  assign reg_rdata  = {cfg_w[reg_addr], {RSV{1'b0}}, cfg_sd[reg_addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fs_prev <= '0;
    else if (soft_rst) fs_prev <= '0;
    else if (dclk_en)  fs_prev <= fs_in;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_sd[g] <= '0;
        cfg_w[g]  <= '0;
      end else if (soft_rst) begin
        cfg_sd[g] <= '0;
        cfg_w[g]  <= '0;
      end else if (reg_we && reg_addr == AW'(g)) begin
        cfg_sd[g] <= reg_wdata[DLY_W-1:0];
        cfg_w[g]  <= reg_wdata[DW-1 -: 2];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph[g]   <= IDLE;
        cnt[g]  <= '0;
        wcnt[g] <= '0;
        wsel[g] <= '0;
      end else if (soft_rst) begin
        ph[g]   <= IDLE;
        cnt[g]  <= '0;
        wcnt[g] <= '0;
        wsel[g] <= '0;
      end else if (rise[g]) begin
        ph[g]   <= (cfg_sd[g] == '0) ? IDLE : DELAY;
        cnt[g]  <= cfg_sd[g];
        wsel[g] <= cfg_w[g];
        wcnt[g] <= '0;
      end else if (dclk_en) begin
        case (ph[g])
          DELAY: begin
            if (cnt[g] == DLY_W'(1)) begin
              ph[g]   <= PULSE;
              wcnt[g] <= width_of(wsel[g]);
            end
            cnt[g] <= cnt[g] - DLY_W'(1);
          end
          PULSE: begin
            if (wcnt[g] == WCW'(1)) ph[g] <= IDLE;
            wcnt[g] <= wcnt[g] - WCW'(1);
          end
          default: ph[g] <= IDLE;
        endcase
      end
    end

    assign fs_out[g] = (ph[g] == PULSE) |
                       ((ph[g] == IDLE) & (cfg_sd[g] == '0) & fs_in[g]);

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[g] && !soft_rst && cfg_sd[g] != '0) |=> ph[g] == DELAY); // R7
    AST_NO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dclk_en && !soft_rst) |=> ($stable(ph[g]) && $stable(cnt[g]) && $stable(wcnt[g]))); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ph[g] != IDLE && !rise[g] && !soft_rst) |=> $stable(wsel[g])); // R8
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ph[g] == IDLE && cfg_sd[g] == '0 && cfg_w[g] == '0)); // R9
    AST_PULSE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph[g] == PULSE) |-> $past(ph[g]) == DELAY); // R3
  end

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ($past(reg_addr) != reg_addr || reg_rdata[DW-3:DLY_W] == '0)); // R2
endmodule

// File: tb/fsync_delay_gen_test.sv
module fsync_delay_gen_test;
  logic clk = 0, rst_n = 0, soft_rst = 0, dclk_en = 0, reg_we = 0;
  logic [3:0] fs_in = '0, fs_out;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0, tick = 0, div = 1;
  int m_sd[4], m_w[4], m_act[4], m_cnt[4], m_d[4], m_wl[4];
  bit m_prev[4];

  always #4 clk = ~clk;

  fsync_delay_gen uut (.clk, .rst_n, .soft_rst, .dclk_en, .fs_in, .reg_we,
                       .reg_addr, .reg_wdata, .reg_rdata, .fs_out);

  function automatic int wlen(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 8 : 16;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 4; c++) begin
      m_sd[c] = 0; m_w[c] = 0; m_act[c] = 0; m_cnt[c] = 0; m_prev[c] = 0;
    end
  endtask

  task automatic model_edge();
    if (!rst_n || soft_rst) begin model_clear(); return; end
    if (dclk_en)
      for (int c = 0; c < 4; c++) begin
        bit r;
        r = fs_in[c] && !m_prev[c];
        m_prev[c] = fs_in[c];
        if (r) begin
          if (m_sd[c] == 0) m_act[c] = 0;
          else begin m_act[c] = 1; m_cnt[c] = 0; m_d[c] = m_sd[c]; m_wl[c] = wlen(m_w[c]); end
        end else if (m_act[c] != 0) begin
          m_cnt[c]++;
          if (m_cnt[c] >= m_d[c] + m_wl[c]) m_act[c] = 0;
        end
      end
    if (reg_we) begin
      m_sd[reg_addr] = reg_wdata[9:0];
      m_w[reg_addr]  = reg_wdata[15:14];
    end
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int c = 0; c < 4; c++) begin
      logic e;
      string tag;
      if (m_act[c] != 0) begin
        e = (m_cnt[c] >= m_d[c]);
        tag = $sformatf("R3 R4 R11 ch%0d pulse", c);
      end else if (m_sd[c] == 0) begin
        e = fs_in[c];
        tag = $sformatf("R6 ch%0d bypass", c);
      end else begin
        e = 1'b0;
        tag = $sformatf("R5 ch%0d idle", c);
      end
      check(tag, {15'd0, fs_out[c]}, {15'd0, e});
    end
    check("R1 readback", reg_rdata,
          {m_w[reg_addr][1:0], 4'b0000, m_sd[reg_addr][9:0]});
  endtask

  task automatic cycle(int n = 1);
    repeat (n) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      tick++;
      dclk_en = (tick % div) == 0;
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    reg_we = 1; reg_addr = 2'(a); reg_wdata = d;
    cycle();
    reg_we = 0;
  endtask

  task automatic sync(logic [3:0] m, int len);
    fs_in = fs_in | m; cycle(len);
    fs_in = fs_in & ~m;
  endtask

  initial begin
    model_clear();
    fs_in = 4'b1010;
    cycle(3);
    check("R9 reset fs_out bypass", {12'd0, fs_out}, 16'h000a);
    rst_n = 1;
    fs_in = 0;
    cycle(2);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check("R9 reset register zero", reg_rdata, 16'h0000);
    end
    wr(0, 16'h3c05); wr(1, 16'h4003); wr(2, 16'hbc01); wr(3, 16'hc007);
    reg_addr = 0; #1;
    check("R2 reserved bits read zero", reg_rdata, 16'h0005);
    reg_addr = 2; #1;
    check("R2 R1 ch2 fields", reg_rdata, 16'h8001);
    sync(4'b1111, 2); cycle(30);
    div = 2;
    sync(4'b0101, 6); cycle(40);
    sync(4'b1000, 40); cycle(20);
    sync(4'b1000, 2); cycle(6);
    sync(4'b1000, 2); cycle(12);
    sync(4'b1000, 2); cycle(20);
    sync(4'b1000, 2); cycle(4);
    wr(3, 16'h0002); cycle(40);
    sync(4'b1000, 2); cycle(20);
    sync(4'b0100, 2); cycle(4);
    wr(2, 16'h0000); cycle(30);
    wr(1, 16'h4005); sync(4'b0010, 2); cycle(4);
    wr(1, 16'hc000); cycle(4);
    sync(4'b0010, 2); cycle(6);
    sync(4'b0010, 4); cycle(6);
    div = 3;
    wr(2, 16'h4004); sync(4'b0100, 3); cycle(40);
    div = 1;
    wr(0, 16'hc3ff); sync(4'b0001, 1); cycle(1060);
    wr(0, 16'h0001); sync(4'b0001, 1); cycle(6);
    wr(3, 16'hc001); sync(4'b1000, 1); cycle(4);
    soft_rst = 1; cycle(); soft_rst = 0;
    check("R9 soft reset clears outputs", {12'd0, fs_out}, 16'h0000);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check("R9 soft reset register zero", reg_rdata, 16'h0000);
    end
    cycle(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule